// File: doc/BRIEF.md
# Program-Order Pipeline Exception Arbiter

This block sits beside a seven-stage in-order pipeline. Stage index 0 is the first fetch stage and index 6 is write-back; the stages in between are second fetch, decode, and three execute stages. Any stage can raise an exception request in any cycle. A request can be an instruction-fetch translation miss, one of five decode-time faults, or a data-access translation miss. Several stages may raise requests in the same cycle. The arbiter accepts the request of the oldest instruction in program order, which is the valid requesting stage with the highest index. It does not go by which stage detected its fault first.

In the cycle of acceptance the arbiter does four things:
- It pulses an accept strobe.
- It reports an encoded cause and the program counter of the faulting instruction.
- It flushes the faulting stage and every younger stage.
- It discards every other request.

It then waits in a held state until the handler signals a restart. One cycle later it pulses a refetch strobe carrying the faulting instruction's address, so that the instruction is executed again from the start. Exceptions on younger instructions are raised again as those instructions pass through the pipeline once more, and each is accepted in its own turn.

The controller has three states:
- **ARMED**: watches the requests.
- **HELD**: an exception has been accepted and the arbiter waits for the restart.
- **REFETCH**: a one-cycle state that issues the refetch strobe.

It has four transitions:
- **ARMED→HELD**: taken on any accepted request.
- **HELD→REFETCH**: taken on restart.
- **REFETCH→ARMED**: taken unconditionally.
- **Stay**: every other case leaves the state unchanged.

Top module: `exc_order_arbiter`

## Requirements
- R1: After reset, `exc_accept`, `exc_flush`, `refetch` and `refetch_pc` are all zero.
- R2: In the ARMED state, if any valid stage requests, `exc_accept` is 1 in the same cycle. `exc_pc` then equals the PC of the highest-index valid requesting stage, which is the oldest in program order. The requests of all younger stages are discarded.
- R3: `exc_cause` encodes the class of the accepted request as follows:
  - 1: fetch translation miss.
  - 2 to 6: a decode fault code `stage_dec_exc` of 1 to 5, giving cause = code+1. Code 1 is general illegal, 2 is slot illegal, 3 is FPU disabled, 4 is slot FPU disabled and 5 is trap.
  - 7: data translation miss.
  - Decode codes 0, 6 and 7 are treated as no request.
- R4: When one stage carries several requests, the fetch miss wins over the decode fault, and the decode fault wins over the data miss.
- R5: `exc_flush` has bits 0 up to the winning stage index set in the accept cycle, and all higher bits clear. It is zero in every other cycle.
- R6: Requests from stages whose `stage_valid` bit is 0 are ignored.
- R7: `exc_accept` lasts a single cycle. No request is accepted in the HELD or REFETCH state.
- R8: From the cycle after acceptance, `refetch_pc` holds the faulting PC. `restart` in the HELD state gives a one-cycle `refetch` pulse in the next cycle.
- R9: In the cycle after the refetch pulse the arbiter is ARMED again and accepts a new request.
- R10: `restart` outside the HELD state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stage_valid | input | NST | Stage holds a valid instruction (bit 0 = first fetch, bit NST-1 = write-back) |
| stage_pc | input | NST*PCW | PC of each stage, stage i at bits [i*PCW +: PCW] |
| stage_itlb_miss | input | NST | Fetch translation miss request per stage |
| stage_dec_exc | input | NST*3 | Decode fault code per stage, stage i at bits [i*3 +: 3] |
| stage_dtlb_miss | input | NST | Data translation miss request per stage |
| restart | input | 1 | Handler finished, resume |
| exc_accept | output | 1 | One-cycle acceptance strobe |
| exc_cause | output | 3 | Cause code of the accepted exception |
| exc_pc | output | PCW | PC of the faulting instruction |
| exc_flush | output | NST | Per-stage invalidate, valid with `exc_accept` |
| refetch | output | 1 | One-cycle strobe to refetch from `refetch_pc` |
| refetch_pc | output | PCW | Held faulting PC |

## Verification
The block's results fall due at three different times:
- **Same cycle**: `exc_accept`, `exc_cause`, `exc_pc` and `exc_flush` are combinational on the stage inputs in the ARMED state. The bench drives inputs on the falling edge and checks them one time unit later, inside the same cycle.
- **One cycle after acceptance**: `refetch_pc` and the HELD state take effect at the next rising edge. The bench checks them at the following falling edge.
- **One cycle after restart**: `refetch` appears in the cycle after the edge that samples `restart`. The bench checks it at the falling edge after that, and checks again one cycle later that the strobe has dropped.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

    localparam int DEC_W = 3;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_ITLB     = 3'd1,
        CAUSE_ILL      = 3'd2,
        CAUSE_SLOT_ILL = 3'd3,
        CAUSE_FPU      = 3'd4,
        CAUSE_SLOT_FPU = 3'd5,
        CAUSE_TRAP     = 3'd6,
        CAUSE_DTLB     = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_HELD    = 2'd1,
        ST_REFETCH = 2'd2
    } arb_state_e;

endpackage

// File: rtl/exc_stage_encode.sv
module exc_stage_encode
    import exc_arb_pkg::*;
(
    input  logic                 valid,
    input  logic                 itlb_miss,
    input  logic [DEC_W-1:0]     dec_exc,
    input  logic                 dtlb_miss,
    output logic [2:0]           cause
);
    logic dec_hit;

    always_comb begin
        dec_hit = (dec_exc >= 3'd1) && (dec_exc <= 3'd5);
        cause   = CAUSE_NONE;
        if (valid) begin
            if (itlb_miss) begin
                cause = CAUSE_ITLB;
            end else if (dec_hit) begin
                cause = dec_exc + 3'd1;
            end else if (dtlb_miss) begin
                cause = CAUSE_DTLB;
            end
        end
    end
endmodule

// File: rtl/exc_oldest_pick.sv
module exc_oldest_pick #(
    parameter int NST = 7,
    localparam int IDXW = (NST > 1) ? $clog2(NST) : 1
) (
    input  logic [NST*3-1:0] causes,
    output logic             found,
    output logic [IDXW-1:0]  win_idx,
    output logic [2:0]       win_cause,
    output logic [NST-1:0]   younger_mask
);
    always_comb begin
        found     = 1'b0;
        win_idx   = '0;
        win_cause = 3'd0;
        for (int i = 0; i < NST; i++) begin
            if (causes[i*3 +: 3] != 3'd0) begin
                found     = 1'b1;
                win_idx   = IDXW'(i);
                win_cause = causes[i*3 +: 3];
            end
        end
        for (int j = 0; j < NST; j++) begin
            younger_mask[j] = found && (IDXW'(j) <= win_idx);
        end
    end
endmodule

// File: rtl/exc_order_arbiter.sv
module exc_order_arbiter
    import exc_arb_pkg::*;
#(
    parameter int NST = 7,
    parameter int PCW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NST-1:0]     stage_valid,
    input  logic [NST*PCW-1:0] stage_pc,
    input  logic [NST-1:0]     stage_itlb_miss,
    input  logic [NST*3-1:0]   stage_dec_exc,
    input  logic [NST-1:0]     stage_dtlb_miss,
    input  logic               restart,
    output logic               exc_accept,
    output logic [2:0]         exc_cause,
    output logic [PCW-1:0]     exc_pc,
    output logic [NST-1:0]     exc_flush,
    output logic               refetch,
    output logic [PCW-1:0]     refetch_pc
);
    localparam int IDXW = (NST > 1) ? $clog2(NST) : 1;

    logic [NST*3-1:0] stage_cause;
    logic             any_req;
    logic [IDXW-1:0]  win_idx;
    logic [2:0]       win_cause;
    logic [NST-1:0]   win_mask;
    arb_state_e       state, state_nx;
    logic [PCW-1:0]   held_pc;

    for (genvar g = 0; g < NST; g++) begin : g_enc
        exc_stage_encode u_enc (
            .valid     (stage_valid[g]),
            .itlb_miss (stage_itlb_miss[g]),
            .dec_exc   (stage_dec_exc[g*3 +: 3]),
            .dtlb_miss (stage_dtlb_miss[g]),
            .cause     (stage_cause[g*3 +: 3])
        );
    end

    exc_oldest_pick #(.NST(NST)) u_pick (
        .causes       (stage_cause),
        .found        (any_req),
        .win_idx      (win_idx),
        .win_cause    (win_cause),
        .younger_mask (win_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARMED;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED:   if (any_req) state_nx = ST_HELD;
            ST_HELD:    if (restart) state_nx = ST_REFETCH;
            ST_REFETCH: state_nx = ST_ARMED;
            default:    state_nx = ST_ARMED;
        endcase
    end

    always_comb begin
        exc_accept = 1'b0;
        exc_cause  = 3'd0;
        exc_pc     = '0;
        exc_flush  = '0;
        refetch    = 1'b0;
        unique case (state)
            ST_ARMED: begin
                if (any_req) begin
                    exc_accept = 1'b1;
                    exc_cause  = win_cause;
                    exc_pc     = stage_pc[win_idx*PCW +: PCW];
                    exc_flush  = win_mask;
                end
            end
            ST_HELD: begin
            end
            ST_REFETCH: begin
                refetch = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_pc <= '0;
        end else if (exc_accept) begin
            held_pc <= exc_pc;
        end
    end

    assign refetch_pc = held_pc;

endmodule

// File: rtl/exc_order_arbiter_chk.sv
module exc_order_arbiter_chk #(
    parameter int NST = 7,
    parameter int PCW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           restart,
    input logic           exc_accept,
    input logic [2:0]     exc_cause,
    input logic [PCW-1:0] exc_pc,
    input logic [NST-1:0] exc_flush,
    input logic           refetch,
    input logic [PCW-1:0] refetch_pc
);
    AST_ACCEPT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_accept |=> !exc_accept); // R7

    AST_NO_ACCEPT_ON_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |-> !exc_accept); // R7

    AST_CAUSE_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        exc_accept |-> (exc_cause != 3'd0)); // R3

    AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_accept |-> (exc_flush == '0)); // R5

    AST_FLUSH_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_accept |-> (exc_flush[0] && ((exc_flush & (exc_flush + NST'(1))) == '0))); // R5

    AST_PC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_accept |=> (refetch_pc == $past(exc_pc))); // R8

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_accept |=> $stable(refetch_pc)); // R8

    AST_REFETCH_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |-> $past(restart)); // R8

    AST_REFETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |=> !refetch); // R9
endmodule

bind exc_order_arbiter exc_order_arbiter_chk #(.NST(NST), .PCW(PCW)) u_chk (.*);

// File: tb/exc_order_arbiter_bench.sv
module exc_order_arbiter_bench;
    localparam int NST = 7;
    localparam int PCW = 32;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NST-1:0]     stage_valid = '0;
    logic [NST*PCW-1:0] stage_pc = '0;
    logic [NST-1:0]     stage_itlb_miss = '0;
    logic [NST*3-1:0]   stage_dec_exc = '0;
    logic [NST-1:0]     stage_dtlb_miss = '0;
    logic               restart = 1'b0;
    logic               exc_accept;
    logic [2:0]         exc_cause;
    logic [PCW-1:0]     exc_pc;
    logic [NST-1:0]     exc_flush;
    logic               refetch;
    logic [PCW-1:0]     refetch_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exc_order_arbiter #(.NST(NST), .PCW(PCW)) u_exc_order_arbiter (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        stage_valid = '0; stage_itlb_miss = '0; stage_dtlb_miss = '0;
        stage_dec_exc = '0;
        for (int i = 0; i < NST; i++) stage_pc[i*PCW +: PCW] = 32'h1000 + 32'(i*4);
    endtask

    task automatic put(input int st, input logic v, input logic it, input logic [2:0] dc, input logic dt);
        stage_valid[st] = v; stage_itlb_miss[st] = it;
        stage_dec_exc[st*3 +: 3] = dc; stage_dtlb_miss[st] = dt;
    endtask

    function automatic logic [31:0] pc_of(input int st);
        return 32'h1000 + 32'(st*4);
    endfunction

    // runs the handler: restart in HELD, check refetch pulse and PC
    task automatic release_to(input string req, input logic [31:0] exp_pc);
        @(negedge clk); clear_in(); restart = 1'b1;
        @(negedge clk); restart = 1'b0; #1;
        chk({req, " refetch pulse"}, 32'(refetch), 32'd1);
        chk({req, " refetch pc"}, refetch_pc, exp_pc);
        @(negedge clk); #1;
        chk({req, " refetch drop"}, 32'(refetch), 32'd0);
    endtask

    task automatic expect_accept(input string req, input logic [2:0] cause, input int st);
        #1;
        chk({req, " accept"}, 32'(exc_accept), 32'd1);
        chk({req, " cause"}, 32'(exc_cause), 32'(cause));
        chk({req, " pc"}, exc_pc, pc_of(st));
        chk({req, " flush"}, 32'(exc_flush), 32'((1 << (st+1)) - 1));
    endtask

    task automatic t_reset();
        #1;
        chk("R1 accept", 32'(exc_accept), 0);
        chk("R1 flush", 32'(exc_flush), 0);
        chk("R1 refetch", 32'(refetch), 0);
        chk("R1 refetch_pc", refetch_pc, 0);
    endtask

    // illegal on n+1 (decode) and fetch miss on n+2 (I2) in same cycle
    task automatic t_program_order();
        @(negedge clk); clear_in();
        put(2, 1, 0, 3'd1, 0); put(1, 1, 1, 3'd0, 0); put(0, 1, 0, 3'd0, 0);
        expect_accept("R2 R5 older wins", 3'd2, 2);
        @(negedge clk); #1;
        chk("R7 held no accept", 32'(exc_accept), 0);
        chk("R8 held pc", refetch_pc, pc_of(2));
        chk("R5 held flush", 32'(exc_flush), 0);
        release_to("R8", pc_of(2));
        clear_in(); put(1, 1, 1, 3'd0, 0);
        expect_accept("R9 younger re-raised", 3'd1, 1);
        release_to("R9", pc_of(1));
    endtask

    task automatic t_intra_priority();
        @(negedge clk); clear_in(); put(3, 1, 1, 3'd2, 1);
        expect_accept("R4 itlb first", 3'd1, 3);
        release_to("R4a", pc_of(3));
        clear_in(); put(3, 1, 0, 3'd2, 1);
        expect_accept("R4 dec over dtlb", 3'd3, 3);
        release_to("R4b", pc_of(3));
    endtask

    task automatic t_codes();
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk); clear_in(); put(2, 1, 0, 3'(c), 0);
            expect_accept("R3 decode code", 3'(c+1), 2);
            release_to("R3", pc_of(2));
        end
        @(negedge clk); clear_in(); put(2, 1, 0, 3'd6, 0); #1;
        chk("R3 code 6 ignored", 32'(exc_accept), 0);
        put(2, 1, 0, 3'd7, 0); #1;
        chk("R3 code 7 ignored", 32'(exc_accept), 0);
        clear_in(); put(5, 1, 0, 3'd0, 1); put(2, 1, 0, 3'd1, 0);
        expect_accept("R3 R2 dtlb older", 3'd7, 5);
        release_to("R3d", pc_of(5));
    endtask

    task automatic t_invalid();
        @(negedge clk); clear_in(); put(4, 0, 0, 3'd0, 1); #1;
        chk("R6 invalid ignored", 32'(exc_accept), 0);
        chk("R6 invalid flush", 32'(exc_flush), 0);
        put(0, 1, 1, 3'd0, 0);
        expect_accept("R6 valid younger wins", 3'd1, 0);
        release_to("R6", pc_of(0));
    endtask

    task automatic t_writeback_all();
        @(negedge clk); clear_in();
        for (int i = 0; i < NST; i++) put(i, 1, 0, 3'd0, 1);
        expect_accept("R5 flush all", 3'd7, 6);
        release_to("R5", pc_of(6));
    endtask

    task automatic t_restart_idle();
        @(negedge clk); clear_in(); restart = 1'b1;
        @(negedge clk); restart = 1'b0; #1;
        chk("R10 no refetch", 32'(refetch), 0);
        put(4, 1, 0, 3'd0, 1);
        expect_accept("R10 still armed", 3'd7, 4);
        @(negedge clk); put(6, 1, 1, 3'd0, 0); #1;
        chk("R7 held ignores", 32'(exc_accept), 0);
        release_to("R10", pc_of(4));
    endtask

    initial begin
        clear_in();
        #(CLK_PERIOD*2 + 2);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_program_order();
        t_intra_priority();
        t_codes();
        t_invalid();
        t_writeback_all();
        t_restart_idle();
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule